// File: doc/BRIEF.md
# Frame-Level Search Window Reuse Scheduler

This block sequences multiple-reference-frame motion estimation so that each reference search window is brought into the local buffer a single time. Once a window is resident, the block walks through the co-located current macroblocks of every later frame that may use that window as a reference. Each of those macroblocks is fetched again for every window it is searched against. Compared with per-macroblock scheduling, the loop order is inverted: the window is fetched once, and the current macroblocks are fetched many times.

Frames are numbered from 0. Frame 0 is the first coded frame and is never a current frame. Predicted frames are 1 to `NUM_FRAMES`. Current frame c uses as references the frames c-1 down to c-`MAX_REF`, keeping only those that are 0 or higher. For every (reference, current, macroblock) task the block does the following in order:

- requests the current macroblock;
- starts the motion-estimation core;
- waits for the core to finish;
- requests a write-out of the partial decision results (motion vectors and costs).

A small counter per current macroblock records the completed references. A ready pulse tells the final-decision stage when the reference set of a macroblock is complete. That set is smaller near the start of the sequence. The default window covers the macroblock plus 16 pixels on each side, but addressing is left to the fetch engine. The block itself issues only frame and macroblock indices.

Top module: `srmc_window_scheduler`

## Requirements
- R1: After reset, every request output, `fmd_ready` and `seq_done` are 0, and the block waits for a `start` pulse.
- R2: The reference frame r is the outer loop (0 to `NUM_FRAMES`-1, ascending), and the macroblock index m is the next loop (0 to `MBS_PER_FRAME`-1, ascending). For each (r, m) there is exactly one window fetch (`sw_req`, with `ref_frame`=r, `mb_idx`=m). After it come tasks for current frames r+1 up to min(r+`MAX_REF`, `NUM_FRAMES`), in ascending order.
- R3: Each task runs in strict order: current-macroblock fetch (`cur_req`), then core start (`me_req`), then partial-result write (`pmd_req`). All three show the task's `ref_frame`, `cur_frame` and `mb_idx`.
- R4: Each request, and the indices shown with it, stays unchanged until its own acknowledge is sampled high at a clock edge. The request drops on that edge.
- R5: Only one core task is outstanding at a time. `pmd_req` rises only in the cycle after `me_done` is sampled high.
- R6: `fmd_ready` is a one-cycle pulse in the cycle after the partial-result write of a macroblock's last valid reference (reference c-1) is acknowledged. Frames with c < `MAX_REF` are ready after only c references.
- R7: `seq_done` pulses once, together with the final `fmd_ready` of the sequence. The block then returns to idle. A later `start` repeats the identical order.
- R8: `start` has no effect while a sequence is in progress.
- R9: At most one of the four request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle |
| sw_req | output | 1 | Search-window fetch request |
| sw_ack | input | 1 | Window fetch accepted |
| cur_req | output | 1 | Current-macroblock fetch request |
| cur_ack | input | 1 | Macroblock fetch accepted |
| me_req | output | 1 | Motion-estimation start command |
| me_ack | input | 1 | Core accepted the task |
| me_done | input | 1 | Core finished the task (one-cycle pulse) |
| pmd_req | output | 1 | Partial-result write request |
| pmd_ack | input | 1 | Partial results written |
| ref_frame | output | FW | Reference frame index |
| cur_frame | output | FW | Current frame index |
| mb_idx | output | MW | Macroblock index within the frame |
| fmd_ready | output | 1 | Macroblock ready for final decision |
| seq_done | output | 1 | Whole sequence scheduled |

## Verification
The assertions assume that the environment raises each acknowledge only while the matching request is high. They also assume that `me_done` arrives only after the core start has been accepted and before the write-out begins. The responder in the bench follows this rule. It answers only the request it currently sees. It waits a varying number of cycles before answering. It pulses `me_done` only after it has accepted a task. The scoreboard compares the order of the accepted handshakes with a list that the bench builds from R2, R3 and R6, using the 6-macroblock, 5-frame, 4-reference configuration.

// File: rtl/srmc_sched_pkg.sv
package srmc_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_CUR,
    ST_ME,
    ST_WAIT,
    ST_PART,
    ST_TALLY
  } sched_st_e;

  // Highest current frame that may use reference frame ref_f.
  function automatic int last_user(int ref_f, int frames, int max_ref);
    return (ref_f + max_ref < frames) ? ref_f + max_ref : frames;
  endfunction

  // Number of references current frame cur_f can have.
  function automatic int valid_refs(int cur_f, int max_ref);
    return (cur_f < max_ref) ? cur_f : max_ref;
  endfunction

endpackage

// File: rtl/srmc_index_walker.sv
module srmc_index_walker
  import srmc_sched_pkg::*;
#(
  parameter int NUM_FRAMES    = 5,
  parameter int MBS_PER_FRAME = 6,
  parameter int MAX_REF       = 4,
  parameter int FW            = 3,
  parameter int MW            = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [FW-1:0] ref_o,
  output logic [FW-1:0] cur_o,
  output logic [MW-1:0] mb_o,
  output logic          last_cur_o,
  output logic          last_mb_o,
  output logic          last_ref_o
);

  logic [FW-1:0] ref_q, cur_q;
  logic [MW-1:0] mb_q;

  assign last_cur_o = (int'(cur_q) == last_user(int'(ref_q), NUM_FRAMES, MAX_REF));
  assign last_mb_o  = (mb_q == MW'(MBS_PER_FRAME - 1));
  assign last_ref_o = (ref_q == FW'(NUM_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      cur_q <= FW'(1);
      mb_q  <= '0;
    end else if (load) begin
      ref_q <= '0;
      cur_q <= FW'(1);
      mb_q  <= '0;
    end else if (step) begin
      if (!last_cur_o) begin
        cur_q <= cur_q + FW'(1);
      end else if (!last_mb_o) begin
        mb_q  <= mb_q + MW'(1);
        cur_q <= ref_q + FW'(1);
      end else if (!last_ref_o) begin
        mb_q  <= '0;
        ref_q <= ref_q + FW'(1);
        cur_q <= ref_q + FW'(2);
      end
    end
  end

  assign ref_o = ref_q;
  assign cur_o = cur_q;
  assign mb_o  = mb_q;

endmodule

// File: rtl/srmc_ref_tally.sv
module srmc_ref_tally
  import srmc_sched_pkg::*;
#(
  parameter int NUM_FRAMES    = 5,
  parameter int MBS_PER_FRAME = 6,
  parameter int MAX_REF       = 4,
  parameter int FW            = 3,
  parameter int MW            = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  input  logic [FW-1:0] cur_i,
  input  logic [MW-1:0] mb_i,
  output logic          final_o
);

  localparam int ENTRIES = NUM_FRAMES * MBS_PER_FRAME;
  localparam int CW      = (MAX_REF > 1) ? $clog2(MAX_REF) : 1;

  logic [CW-1:0]      cnt_q [ENTRIES];
  logic [ENTRIES-1:0] sel;
  logic [CW-1:0]      cur_cnt;
  int                 slot;

  always_comb slot = (int'(cur_i) - 1) * MBS_PER_FRAME + int'(mb_i);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign sel[e] = (slot == e);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[e] <= '0;
      else if (bump && sel[e])
        cnt_q[e] <= final_o ? '0 : cnt_q[e] + 1'b1;
    end
  end

  always_comb begin
    cur_cnt = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (sel[e]) cur_cnt = cnt_q[e];
  end

  // The count holds completed references minus nothing; this bump closes the set.
  assign final_o = (int'(cur_cnt) == valid_refs(int'(cur_i), MAX_REF) - 1);

endmodule

// File: rtl/srmc_window_scheduler.sv
module srmc_window_scheduler
  import srmc_sched_pkg::*;
#(
  parameter int NUM_FRAMES    = 5,
  parameter int MBS_PER_FRAME = 6,
  parameter int MAX_REF       = 4,
  localparam int FW = $clog2(NUM_FRAMES + 1),
  localparam int MW = (MBS_PER_FRAME > 1) ? $clog2(MBS_PER_FRAME) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          sw_req,
  input  logic          sw_ack,
  output logic          cur_req,
  input  logic          cur_ack,
  output logic          me_req,
  input  logic          me_ack,
  input  logic          me_done,
  output logic          pmd_req,
  input  logic          pmd_ack,
  output logic [FW-1:0] ref_frame,
  output logic [FW-1:0] cur_frame,
  output logic [MW-1:0] mb_idx,
  output logic          fmd_ready,
  output logic          seq_done
);

  sched_st_e state_q, state_d;

  logic walk_load, walk_step;
  logic last_cur, last_mb, last_ref, seq_last;
  logic tally_bump, tally_hit;

  assign walk_load  = (state_q == ST_IDLE) && start;
  assign tally_bump = (state_q == ST_TALLY);
  assign walk_step  = tally_bump;
  assign seq_last   = last_cur && last_mb && last_ref;

  srmc_index_walker #(
    .NUM_FRAMES(NUM_FRAMES), .MBS_PER_FRAME(MBS_PER_FRAME),
    .MAX_REF(MAX_REF), .FW(FW), .MW(MW)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step),
    .ref_o(ref_frame), .cur_o(cur_frame), .mb_o(mb_idx),
    .last_cur_o(last_cur), .last_mb_o(last_mb), .last_ref_o(last_ref)
  );

  srmc_ref_tally #(
    .NUM_FRAMES(NUM_FRAMES), .MBS_PER_FRAME(MBS_PER_FRAME),
    .MAX_REF(MAX_REF), .FW(FW), .MW(MW)
  ) u_tally (
    .clk(clk), .rst_n(rst_n), .bump(tally_bump),
    .cur_i(cur_frame), .mb_i(mb_idx), .final_o(tally_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)   state_d = ST_WIN;
      ST_WIN:   if (sw_ack)  state_d = ST_CUR;
      ST_CUR:   if (cur_ack) state_d = ST_ME;
      ST_ME:    if (me_ack)  state_d = ST_WAIT;
      ST_WAIT:  if (me_done) state_d = ST_PART;
      ST_PART:  if (pmd_ack) state_d = ST_TALLY;
      ST_TALLY: state_d = seq_last ? ST_IDLE : (last_cur ? ST_WIN : ST_CUR);
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign sw_req    = (state_q == ST_WIN);
  assign cur_req   = (state_q == ST_CUR);
  assign me_req    = (state_q == ST_ME);
  assign pmd_req   = (state_q == ST_PART);
  assign fmd_ready = tally_bump && tally_hit;
  assign seq_done  = tally_bump && seq_last;

endmodule

// File: rtl/srmc_window_scheduler_chk.sv
module srmc_window_scheduler_chk #(
  parameter int NUM_FRAMES    = 5,
  parameter int MBS_PER_FRAME = 6,
  parameter int MAX_REF       = 4,
  parameter int FW            = 3,
  parameter int MW            = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_req,
  input logic          sw_ack,
  input logic          cur_req,
  input logic          cur_ack,
  input logic          me_req,
  input logic          me_ack,
  input logic          me_done,
  input logic          pmd_req,
  input logic          pmd_ack,
  input logic [FW-1:0] ref_frame,
  input logic [FW-1:0] cur_frame,
  input logic [MW-1:0] mb_idx,
  input logic          fmd_ready,
  input logic          seq_done
);

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_req, cur_req, me_req, pmd_req}));

  p_hold_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req && !sw_ack |=> sw_req && $stable(ref_frame) && $stable(mb_idx));

  p_hold_current_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_req && !cur_ack |=> cur_req && $stable(cur_frame) && $stable(ref_frame) && $stable(mb_idx));

  p_hold_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
    me_req && !me_ack |=> me_req && $stable(cur_frame) && $stable(ref_frame));

  p_write_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pmd_req) |-> $past(me_done));

  p_core_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(me_req) |-> $past(cur_req && cur_ack));

  p_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_req |-> (cur_frame > ref_frame) && (int'(cur_frame) - int'(ref_frame) <= MAX_REF));

  p_ready_last_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fmd_ready |-> (int'(ref_frame) + 1 == int'(cur_frame)));

  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fmd_ready |=> !fmd_ready);

  p_done_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> fmd_ready && (int'(ref_frame) == NUM_FRAMES - 1) && (int'(mb_idx) == MBS_PER_FRAME - 1));

endmodule

bind srmc_window_scheduler srmc_window_scheduler_chk #(
  .NUM_FRAMES(NUM_FRAMES), .MBS_PER_FRAME(MBS_PER_FRAME),
  .MAX_REF(MAX_REF), .FW(FW), .MW(MW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_ack(sw_ack),
  .cur_req(cur_req), .cur_ack(cur_ack), .me_req(me_req), .me_ack(me_ack),
  .me_done(me_done), .pmd_req(pmd_req), .pmd_ack(pmd_ack),
  .ref_frame(ref_frame), .cur_frame(cur_frame), .mb_idx(mb_idx),
  .fmd_ready(fmd_ready), .seq_done(seq_done)
);

// File: tb/srmc_window_scheduler_test.sv
module srmc_window_scheduler_test;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 5;
  localparam int NM = 6;
  localparam int NR = 4;
  localparam int FW = $clog2(NF + 1);
  localparam int MW = $clog2(NM);

  localparam int K_SW = 0, K_CUR = 1, K_ME = 2, K_PMD = 3, K_FMD = 4, K_END = 5;

  typedef struct { int kind; int rf; int cf; int mb; } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sw_ack = 1'b0, cur_ack = 1'b0, me_ack = 1'b0, me_done = 1'b0, pmd_ack = 1'b0;
  logic sw_req, cur_req, me_req, pmd_req, fmd_ready, seq_done;
  logic [FW-1:0] ref_frame, cur_frame;
  logic [MW-1:0] mb_idx;

  int checks = 0;
  int fails  = 0;
  int end_count = 0;
  ev_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  srmc_window_scheduler #(.NUM_FRAMES(NF), .MBS_PER_FRAME(NM), .MAX_REF(NR)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sw_req(sw_req), .sw_ack(sw_ack), .cur_req(cur_req), .cur_ack(cur_ack),
    .me_req(me_req), .me_ack(me_ack), .me_done(me_done),
    .pmd_req(pmd_req), .pmd_ack(pmd_ack),
    .ref_frame(ref_frame), .cur_frame(cur_frame), .mb_idx(mb_idx),
    .fmd_ready(fmd_ready), .seq_done(seq_done)
  );

  task automatic check(input bit ok, input string tag, input string got, input string want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %s expected %s", tag, got, want);
    end
  endtask

  // Driver: expected handshake order built from the requirements.
  task automatic push_sequence();
    for (int r = 0; r < NF; r++)
      for (int m = 0; m < NM; m++) begin
        exp_q.push_back('{K_SW, r, -1, m});
        for (int c = r + 1; c <= NF && c <= r + NR; c++) begin
          exp_q.push_back('{K_CUR, r, c, m});
          exp_q.push_back('{K_ME, r, c, m});
          exp_q.push_back('{K_PMD, r, c, m});
          if (r == c - 1) exp_q.push_back('{K_FMD, r, c, m});
          if (r == NF - 1 && m == NM - 1 && c == NF) exp_q.push_back('{K_END, r, c, m});
        end
      end
  endtask

  function automatic string tag_of(int kind);
    case (kind)
      K_SW:    return "R2 window fetch";
      K_CUR:   return "R3 macroblock fetch";
      K_ME:    return "R3 core start";
      K_PMD:   return "R5 partial write";
      K_FMD:   return "R6 final ready";
      default: return "R7 sequence done";
    endcase
  endfunction

  task automatic observe(input int kind);
    ev_t e;
    int cf;
    cf = (kind == K_SW || kind == K_END) ? -1 : int'(cur_frame);
    if (exp_q.size() == 0) begin
      check(1'b0, tag_of(kind), $sformatf("kind %0d r%0d c%0d m%0d", kind, ref_frame, cf, mb_idx), "no event");
      return;
    end
    e = exp_q.pop_front();
    if (e.kind == K_END) e.cf = -1;
    check(e.kind == kind && e.rf == int'(ref_frame) && e.cf == cf && e.mb == int'(mb_idx),
          tag_of(e.kind),
          $sformatf("kind %0d r%0d c%0d m%0d", kind, ref_frame, cf, mb_idx),
          $sformatf("kind %0d r%0d c%0d m%0d", e.kind, e.rf, e.cf, e.mb));
  endtask

  // Responder: acknowledges whichever request is visible after a varying delay.
  initial begin
    int dly = -1;
    int k = 0;
    int md = 0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      sw_ack = 1'b0; cur_ack = 1'b0; me_ack = 1'b0; pmd_ack = 1'b0; me_done = 1'b0;
      if (pend) begin
        if (md == 0) begin me_done = 1'b1; pend = 1'b0; end
        else md--;
      end else if (sw_req || cur_req || me_req || pmd_req) begin
        if (dly < 0) begin dly = k % 3; k++; end
        if (dly == 0) begin
          dly = -1;
          if (sw_req)  sw_ack  = 1'b1;
          if (cur_req) cur_ack = 1'b1;
          if (pmd_req) pmd_ack = 1'b1;
          if (me_req) begin me_ack = 1'b1; pend = 1'b1; md = (k * 5) % 4; end
        end else dly--;
      end
    end
  end

  // Monitor: samples after the responder has settled, well before the next edge.
  initial begin
    logic [3:0] prev_req = '0;
    logic [3:0] prev_ack = '0;
    logic [FW-1:0] prev_rf = '0, prev_cf = '0;
    logic [MW-1:0] prev_mb = '0;
    logic prev_fmd = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (!$onehot0({sw_req, cur_req, me_req, pmd_req}))
          check(1'b0, "R9 single request", $sformatf("%b", {sw_req, cur_req, me_req, pmd_req}), "one-hot or zero");
        if ((prev_req & ~prev_ack) != 0)
          check(prev_req == {sw_req, cur_req, me_req, pmd_req} && prev_rf == ref_frame &&
                prev_cf == cur_frame && prev_mb == mb_idx, "R4 request held",
                $sformatf("req %b r%0d c%0d m%0d", {sw_req, cur_req, me_req, pmd_req}, ref_frame, cur_frame, mb_idx),
                $sformatf("req %b r%0d c%0d m%0d", prev_req, prev_rf, prev_cf, prev_mb));
        if (prev_fmd && fmd_ready) check(1'b0, "R6 pulse width", "2 cycles", "1 cycle");
        if (sw_req && sw_ack)   observe(K_SW);
        if (cur_req && cur_ack) observe(K_CUR);
        if (me_req && me_ack)   observe(K_ME);
        if (pmd_req && pmd_ack) observe(K_PMD);
        if (fmd_ready)          observe(K_FMD);
        if (seq_done) begin observe(K_END); end_count++; end
      end
      prev_req = {sw_req, cur_req, me_req, pmd_req};
      prev_ack = {sw_ack, cur_ack, me_ack, pmd_ack};
      prev_rf = ref_frame; prev_cf = cur_frame; prev_mb = mb_idx;
      prev_fmd = fmd_ready;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected sequence end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [FW-1:0] s_rf, s_cf;
    logic [MW-1:0] s_mb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check({sw_req, cur_req, me_req, pmd_req, fmd_ready, seq_done} == 6'b0, "R1 reset state",
          $sformatf("%b", {sw_req, cur_req, me_req, pmd_req, fmd_ready, seq_done}), "000000");
    repeat (3) @(negedge clk);
    #2;
    check({sw_req, cur_req, me_req, pmd_req} == 4'b0, "R1 waits for start",
          $sformatf("%b", {sw_req, cur_req, me_req, pmd_req}), "0000");

    push_sequence();
    pulse_start();

    // R8: start while a core task is outstanding mid-sequence.
    do begin @(negedge clk); #2; end while (!(me_req && me_ack && int'(ref_frame) == 2));
    @(negedge clk);
    s_rf = ref_frame; s_cf = cur_frame; s_mb = mb_idx;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    #2;
    check(!sw_req && ref_frame == s_rf && cur_frame == s_cf && mb_idx == s_mb, "R8 start ignored",
          $sformatf("sw%0d r%0d c%0d m%0d", sw_req, ref_frame, cur_frame, mb_idx),
          $sformatf("sw0 r%0d c%0d m%0d", s_rf, s_cf, s_mb));

    wait (end_count == 1);
    repeat (4) begin
      @(negedge clk); #2;
      check({sw_req, cur_req, me_req, pmd_req} == 4'b0, "R7 idle after sequence",
            $sformatf("%b", {sw_req, cur_req, me_req, pmd_req}), "0000");
    end
    check(exp_q.size() == 0, "R2 first pass complete", $sformatf("%0d left", exp_q.size()), "0 left");

    push_sequence();
    pulse_start();
    wait (end_count == 2);
    @(negedge clk); #2;
    check(exp_q.size() == 0, "R7 second pass identical", $sformatf("%0d left", exp_q.size()), "0 left");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule